// File: doc/BRIEF.md
# Downstream Port Power and Over-Current Controller

This block sits between the hub's port control logic and the external power switches of seven downstream ports. It holds the powered state of each port, drives open-drain style enable lines toward the power switches, and turns the active-low over-current flags coming back from those switches into per-port over-current status bits that software reads and clears.

Three power arrangements are supported, chosen once after reset from a two-bit configuration strap. In the individual arrangement every port has its own enable line and its own over-current input. In the ganged arrangement one enable line feeds all ports and one over-current input covers all of them. In the two-group arrangement one enable line still feeds all ports, but the over-current inputs are split so that one input covers ports 0 to 3 and a second covers ports 4 to 6. The block also reports the chosen arrangement through the two hub-characteristics fields and enables internal pull-ups on the over-current inputs the arrangement leaves unused.

All inputs and outputs are plain control and status pins; there is no streaming data path, so no valid/ready handshake applies.

Top module: `hub_port_power`

## Requirements
- R1: On the first clock edge after reset at which `cfg_done` is high, `mode_sel` is captured and `cfg_locked` goes high one cycle later; later values of `mode_sel` and `cfg_done` have no effect until the next reset. While `cfg_locked` is low, power requests are ignored, every port reads unpowered and no enable is driven.
- R2: The strap is decoded as: `mode_sel` = 2'b11 individual, 2'b01 two-group, 2'b00 ganged; the unassigned value 2'b10 also selects ganged.
- R3: When locked, a pulse on `pwr_set[i]` makes `port_powered[i]` high and a pulse on `pwr_clr[i]` makes it low, both visible one cycle after the edge that samples the request; a set and a clear in the same cycle leave the port powered.
- R4: `pwr_oe[i]` high means enable line i is pulled low (switch on); low means the line is released. In individual mode `pwr_oe[i]` equals `port_powered[i]`. In ganged and two-group modes only `pwr_oe[0]` is used, high exactly while at least one port is powered, and `pwr_oe[6:1]` stay low.
- R5: Over-current inputs `oc_n` are active low and pass a two-stage synchronizer: an input that goes low between two edges sets its status bit in `port_oc` at the third rising edge after the change.
- R6: In individual mode, over-current input i sets only `port_oc[i]` and powers off only port i.
- R7: In ganged mode, only input 0 is observed; it sets all seven `port_oc` bits and powers off all ports. Other inputs have no effect.
- R8: In two-group mode, input 0 sets `port_oc[3:0]`, input 4 sets `port_oc[6:4]`, and either event powers off every port; other inputs have no effect.
- R9: A `port_oc` bit stays set until a pulse on `oc_clr[i]` clears it; if the over-current event is still present in that cycle, the bit stays set.
- R10: While an over-current event removes power from a port, a set request for that port in the same cycle is overridden and the port stays unpowered.
- R11: `oc_pullup_en[i]` is high for every input the locked mode does not observe and low for observed inputs; before lock all pull-ups are enabled.
- R12: `chr_pwr_mode` reads 2'b01 in individual mode and 2'b00 otherwise; `chr_oc_mode` reads 2'b00 in ganged mode and 2'b01 otherwise (both 2'b00 before lock).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Power arrangement strap, sampled once |
| cfg_done | input | 1 | End of configuration stage |
| pwr_set | input | 7 | Per-port power-on request pulses |
| pwr_clr | input | 7 | Per-port power-off request pulses |
| oc_clr | input | 7 | Per-port over-current status clear pulses |
| oc_n | input | 7 | Asynchronous active-low over-current inputs |
| cfg_locked | output | 1 | Arrangement captured and running |
| pwr_oe | output | 7 | Enable-line drive: 1 pulls the line low |
| port_powered | output | 7 | Per-port powered state |
| port_oc | output | 7 | Per-port held over-current status |
| oc_pullup_en | output | 7 | Pull-up enable for unobserved over-current inputs |
| chr_pwr_mode | output | 2 | Logical power switching field |
| chr_oc_mode | output | 2 | Over-current protection field |

## Verification
The assertions assume that `cfg_done` and the request pulses are synchronous to `clk`, and that reset is applied once before use so the strap is captured exactly once. The stimulus drives every input on the falling edge, holds over-current inputs low for several cycles so the synchronizer sees them, and changes `mode_sel` after lock only to show that it is ignored. Each arrangement is entered from a fresh reset, including the unassigned strap value.

// File: rtl/hpc_pkg.sv
package hpc_pkg;
  typedef enum logic [1:0] {
    MODE_GANGED = 2'd0,
    MODE_GROUPS = 2'd1,
    MODE_INDIV  = 2'd2
  } pmode_e;

  function automatic pmode_e decode_strap(input logic [1:0] strap);
    case (strap)
      2'b11:   decode_strap = MODE_INDIV;
      2'b01:   decode_strap = MODE_GROUPS;
      default: decode_strap = MODE_GANGED;
    endcase
  endfunction
endpackage

// File: rtl/hpc_oc_sync.sv
module hpc_oc_sync #(
  parameter int WIDTH  = 7,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_n,
  output logic [WIDTH-1:0] hit
);
  logic [WIDTH-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '1;
          else        stg[s] <= raw_n;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '1;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign hit = ~stg[STAGES-1];
endmodule

// File: rtl/hpc_oc_map.sv
module hpc_oc_map
  import hpc_pkg::*;
#(
  parameter int NUM_PORTS = 7,
  parameter int GROUP_A   = 4
) (
  input  pmode_e               mode,
  input  logic                 locked,
  input  logic [NUM_PORTS-1:0] hit,
  output logic [NUM_PORTS-1:0] event_o,
  output logic [NUM_PORTS-1:0] kill,
  output logic [NUM_PORTS-1:0] used
);
  localparam int LEAD_B = GROUP_A;

  logic any_event;
  assign any_event = |event_o;

  generate
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
      always_comb begin
        unique case (mode)
          MODE_INDIV: begin
            event_o[i] = locked & hit[i];
            used[i]    = locked;
          end
          MODE_GROUPS: begin
            event_o[i] = locked & ((i < GROUP_A) ? hit[0] : hit[LEAD_B]);
            used[i]    = locked & ((i == 0) || (i == LEAD_B));
          end
          default: begin
            event_o[i] = locked & hit[0];
            used[i]    = locked & (i == 0);
          end
        endcase
        kill[i] = (mode == MODE_INDIV) ? event_o[i] : any_event;
      end
    end
  endgenerate
endmodule

// File: rtl/hpc_port_state.sv
module hpc_port_state #(
  parameter int NUM_PORTS = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 locked,
  input  logic [NUM_PORTS-1:0] set_req,
  input  logic [NUM_PORTS-1:0] clr_req,
  input  logic [NUM_PORTS-1:0] flag_clr,
  input  logic [NUM_PORTS-1:0] event_i,
  input  logic [NUM_PORTS-1:0] kill,
  output logic [NUM_PORTS-1:0] powered,
  output logic [NUM_PORTS-1:0] flag
);
  generate
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          powered[i] <= 1'b0;
          flag[i]    <= 1'b0;
        end else if (locked) begin
          if (kill[i])         powered[i] <= 1'b0;
          else if (set_req[i]) powered[i] <= 1'b1;
          else if (clr_req[i]) powered[i] <= 1'b0;
          flag[i] <= event_i[i] | (flag[i] & ~flag_clr[i]);
        end
      end
    end
  endgenerate
endmodule

// File: rtl/hub_port_power.sv
module hub_port_power
  import hpc_pkg::*;
#(
  parameter int NUM_PORTS   = 7,
  parameter int GROUP_A     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           mode_sel,
  input  logic                 cfg_done,
  input  logic [NUM_PORTS-1:0] pwr_set,
  input  logic [NUM_PORTS-1:0] pwr_clr,
  input  logic [NUM_PORTS-1:0] oc_clr,
  input  logic [NUM_PORTS-1:0] oc_n,
  output logic                 cfg_locked,
  output logic [NUM_PORTS-1:0] pwr_oe,
  output logic [NUM_PORTS-1:0] port_powered,
  output logic [NUM_PORTS-1:0] port_oc,
  output logic [NUM_PORTS-1:0] oc_pullup_en,
  output logic [1:0]           chr_pwr_mode,
  output logic [1:0]           chr_oc_mode
);
  pmode_e               mode_q;
  logic [NUM_PORTS-1:0] hit, ev, kill, used;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= MODE_GANGED;
      cfg_locked <= 1'b0;
    end else if (!cfg_locked && cfg_done) begin
      mode_q     <= decode_strap(mode_sel);
      cfg_locked <= 1'b1;
    end
  end

  hpc_oc_sync #(.WIDTH(NUM_PORTS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_n(oc_n), .hit(hit)
  );

  hpc_oc_map #(.NUM_PORTS(NUM_PORTS), .GROUP_A(GROUP_A)) u_map (
    .mode(mode_q), .locked(cfg_locked), .hit(hit),
    .event_o(ev), .kill(kill), .used(used)
  );

  hpc_port_state #(.NUM_PORTS(NUM_PORTS)) u_state (
    .clk(clk), .rst_n(rst_n), .locked(cfg_locked),
    .set_req(pwr_set), .clr_req(pwr_clr), .flag_clr(oc_clr),
    .event_i(ev), .kill(kill), .powered(port_powered), .flag(port_oc)
  );

  generate
    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_oe
      if (i == 0) begin : g_shared
        assign pwr_oe[i] = (mode_q == MODE_INDIV) ? port_powered[i] : |port_powered;
      end else begin : g_own
        assign pwr_oe[i] = (mode_q == MODE_INDIV) & port_powered[i];
      end
    end
  endgenerate

  assign oc_pullup_en = ~used;
  assign chr_pwr_mode = (mode_q == MODE_INDIV)  ? 2'b01 : 2'b00;
  assign chr_oc_mode  = (mode_q == MODE_GANGED) ? 2'b00 : 2'b01;
endmodule

// File: rtl/hpc_checker.sv
module hpc_checker #(
  parameter int NUM_PORTS = 7
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_PORTS-1:0] oc_clr,
  input logic                 cfg_locked,
  input logic [NUM_PORTS-1:0] pwr_oe,
  input logic [NUM_PORTS-1:0] port_powered,
  input logic [NUM_PORTS-1:0] port_oc,
  input logic [NUM_PORTS-1:0] oc_pullup_en,
  input logic [1:0]           chr_pwr_mode,
  input logic [1:0]           chr_oc_mode
);
  p_unlocked_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_locked |-> (port_powered == '0 && pwr_oe == '0 && port_oc == '0));

  p_lock_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_locked |=> (cfg_locked && $stable(chr_pwr_mode) && $stable(chr_oc_mode)));

  p_shared_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_locked && chr_pwr_mode == 2'b00) |-> (pwr_oe[NUM_PORTS-1:1] == '0));

  p_shared_line_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_locked && chr_pwr_mode == 2'b00) |-> (pwr_oe[0] == (port_powered != '0)));

  p_shared_trip_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((port_oc & ~$past(port_oc)) != '0 && chr_pwr_mode == 2'b00) |-> (port_powered == '0));

  p_trip_unpowers_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((port_oc & ~$past(port_oc)) != '0) |-> ((port_powered & port_oc & ~$past(port_oc)) == '0));

  p_flag_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((port_oc & ~oc_clr) != '0) |=> ((port_oc & $past(port_oc & ~oc_clr)) == $past(port_oc & ~oc_clr)));

  p_indiv_no_pullup_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_locked && chr_pwr_mode == 2'b01) |-> (oc_pullup_en == '0));

  p_ganged_one_input_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_locked && chr_oc_mode == 2'b00) |-> ($countones(~oc_pullup_en) == 1 && !oc_pullup_en[0]));

  p_field_pair_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_pwr_mode == 2'b01) |-> (chr_oc_mode == 2'b01));
endmodule

bind hub_port_power hpc_checker #(.NUM_PORTS(NUM_PORTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .oc_clr(oc_clr), .cfg_locked(cfg_locked),
  .pwr_oe(pwr_oe), .port_powered(port_powered), .port_oc(port_oc),
  .oc_pullup_en(oc_pullup_en), .chr_pwr_mode(chr_pwr_mode), .chr_oc_mode(chr_oc_mode)
);

// File: tb/tb_hub_port_power.sv
module tb_hub_port_power;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode_sel = 2'b11;
  logic          cfg_done = 1'b0;
  logic [NP-1:0] pwr_set = '0, pwr_clr = '0, oc_clr = '0, oc_n = '1;
  logic          cfg_locked;
  logic [NP-1:0] pwr_oe, port_powered, port_oc, oc_pullup_en;
  logic [1:0]    chr_pwr_mode, chr_oc_mode;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hub_port_power dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cfg_done(cfg_done),
    .pwr_set(pwr_set), .pwr_clr(pwr_clr), .oc_clr(oc_clr), .oc_n(oc_n),
    .cfg_locked(cfg_locked), .pwr_oe(pwr_oe), .port_powered(port_powered),
    .port_oc(port_oc), .oc_pullup_en(oc_pullup_en),
    .chr_pwr_mode(chr_pwr_mode), .chr_oc_mode(chr_oc_mode)
  );

  // Reference model: 0 individual, 1 two-group, 2 ganged
  bit            m_locked;
  int            m_mode;
  bit [NP-1:0]   m_pw, m_oc, m_s1, m_s2;
  bit            m_hist[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_locked = 0; m_mode = 2; m_pw = '0; m_oc = '0; m_s1 = '1; m_s2 = '1;
    end else begin
      bit [NP-1:0] hit, ev, kl;
      hit = ~m_s2;
      ev = '0;
      if (m_locked) begin
        for (int i = 0; i < NP; i++) begin
          if (m_mode == 0)      ev[i] = hit[i];
          else if (m_mode == 1) ev[i] = (i < 4) ? hit[0] : hit[4];
          else                  ev[i] = hit[0];
        end
        kl = (m_mode == 0) ? ev : ((ev != 0) ? '1 : '0);
        for (int i = 0; i < NP; i++) begin
          if (kl[i])          m_pw[i] = 0;
          else if (pwr_set[i]) m_pw[i] = 1;
          else if (pwr_clr[i]) m_pw[i] = 0;
          m_oc[i] = ev[i] | (m_oc[i] & ~oc_clr[i]);
        end
      end
      m_s2 = m_s1;
      m_s1 = oc_n;
      if (!m_locked && cfg_done) begin
        m_locked = 1;
        m_mode = (mode_sel == 2'b11) ? 0 : (mode_sel == 2'b01) ? 1 : 2;
      end
    end
  end

  task automatic check(string tag, string what, logic [NP-1:0] act, logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      bit [NP-1:0] e_oe, e_pu;
      bit [1:0] e_pm, e_om;
      if (m_mode == 0) e_oe = m_pw;
      else e_oe = {{(NP-1){1'b0}}, (m_pw != 0)};
      if (!m_locked)        e_pu = '1;
      else if (m_mode == 0) e_pu = '0;
      else if (m_mode == 1) e_pu = 7'b1101110;
      else                  e_pu = 7'b1111110;
      e_pm = (m_mode == 0) ? 2'b01 : 2'b00;
      e_om = (m_mode == 2) ? 2'b00 : 2'b01;
      check("R1", "locked", {6'b0, cfg_locked}, {6'b0, m_locked});
      check("R3", "powered", port_powered, m_pw);
      check("R4", "enable drive", pwr_oe, e_oe);
      check("R9", "oc status", port_oc, m_oc);
      check("R11", "pullups", oc_pullup_en, e_pu);
      check("R12", "fields", {3'b0, chr_pwr_mode, chr_oc_mode}, {3'b0, e_pm, e_om});
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(logic [1:0] strap);
    @(negedge clk);
    rst_n = 0; pwr_set = '0; pwr_clr = '0; oc_clr = '0; oc_n = '1; cfg_done = 0;
    mode_sel = strap;
    tick(3);
    rst_n = 1;
    tick(1);
    cfg_done = 1;
    tick(1);
    cfg_done = 0;
    tick(1);
  endtask

  task automatic pulse(logic [NP-1:0] s, logic [NP-1:0] c, logic [NP-1:0] k);
    pwr_set = s; pwr_clr = c; oc_clr = k;
    tick(1);
    pwr_set = '0; pwr_clr = '0; oc_clr = '0;
  endtask

  initial begin : watchdog
    while (cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // Reset state and requests before lock (R1)
    tick(2);
    check("R1", "reset powered", port_powered, '0);
    check("R11", "reset pullups", oc_pullup_en, '1);
    rst_n = 1;
    pulse('1, '0, '0);
    tick(1);
    check("R1", "ignored before lock", port_powered, '0);
    mode_sel = 2'b11; cfg_done = 1; tick(1); cfg_done = 0; tick(1);

    // Individual mode
    check("R2", "strap 11 field", {5'b0, chr_pwr_mode}, 7'b0000001);
    mode_sel = 2'b00; cfg_done = 1; tick(1); cfg_done = 0; tick(1);
    check("R1", "strap frozen", {5'b0, chr_pwr_mode}, 7'b0000001);
    pulse(7'b0000101, '0, '0);
    check("R3", "set ports 0,2", port_powered, 7'b0000101);
    check("R4", "own lines", pwr_oe, 7'b0000101);
    pulse(7'b0000001, 7'b0000101, '0);
    check("R3", "set beats clear", port_powered, 7'b0000001);
    pulse(7'b0000100, '0, '0);
    oc_n = 7'b1111011;
    tick(2);
    check("R5", "not yet after two edges", port_oc, '0);
    tick(1);
    check("R5", "flag on third edge", port_oc, 7'b0000100);
    check("R6", "only port 2 off", port_powered, 7'b0000001);
    pulse('0, '0, 7'b0000100);
    check("R9", "clear while present", port_oc, 7'b0000100);
    oc_n = '1;
    tick(4);
    check("R9", "held after release", port_oc, 7'b0000100);
    pulse('0, '0, 7'b0000100);
    check("R9", "cleared", port_oc, '0);
    oc_n = 7'b1111101;
    tick(4);
    pulse(7'b0000010, '0, '0);
    check("R10", "trip beats set", port_powered, 7'b0000001);
    oc_n = '1;
    tick(4);

    // Ganged mode
    do_reset(2'b00);
    pulse(7'b0101000, '0, '0);
    check("R4", "shared line on", pwr_oe, 7'b0000001);
    pulse('0, 7'b0001000, '0);
    check("R4", "shared line held", pwr_oe, 7'b0000001);
    oc_n = 7'b1110111;
    tick(4);
    check("R7", "unobserved input", port_oc, '0);
    oc_n = 7'b1111110;
    tick(3);
    check("R7", "all flagged", port_oc, '1);
    check("R7", "all off", port_powered, '0);
    oc_n = '1;
    tick(4);

    // Two-group mode
    do_reset(2'b01);
    pulse('1, '0, '0);
    check("R8", "all powered", port_powered, '1);
    oc_n = 7'b1101111;
    tick(3);
    check("R8", "upper group flagged", port_oc, 7'b1110000);
    check("R8", "all off", port_powered, '0);
    oc_n = '1;
    tick(4);
    pulse('1, '0, '1);
    oc_n = 7'b1111110;
    tick(3);
    check("R8", "lower group flagged", port_oc, 7'b0001111);
    oc_n = '1;
    tick(4);

    // Unassigned strap
    do_reset(2'b10);
    check("R2", "strap 10 pullups", oc_pullup_en, 7'b1111110);
    check("R12", "strap 10 fields", {3'b0, chr_pwr_mode, chr_oc_mode}, '0);
    tick(2);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule